// File: doc/BRIEF.md
# Clockless Eight-Word Latch RAM with Shared Data Bus

A small static memory of eight words, eight bits each. It has no clock: every bit is a level-sensitive latch. A 3-bit address selects one word. Three active-high controls gate access: a select, a read strobe and a write strobe. All data moves over one 8-bit bidirectional bus.

While the block is selected and the write strobe is high, the addressed word is transparent. It follows the bus and keeps the last value when the strobe falls. While the block is selected and the read strobe is high, the block drives the addressed word onto the bus, and the read path is purely combinational. In every other case the block leaves the bus undriven, so other devices can share it.

Read and write are never high together. If they were, the write would take effect and the bus would not be driven. Contents after power-up are undefined.

Top module: `latram_8x8`

## Requirements
- R1: While cs_i=1 and wr_i=1, the word selected by addr_i takes the value on data_io.
- R2: While cs_i=1, rd_i=1 and wr_i=0, data_io carries the word selected by addr_i.
- R3: While cs_i=0, the block does not drive data_io, whatever rd_i and wr_i are.
- R4: While cs_i=1, rd_i=0 and wr_i=0, the block does not drive data_io.
- R5: A write strobe with cs_i=0 leaves every stored word unchanged.
- R6: A word is transparent while its write is active. After wr_i falls, it holds the last bus value seen.
- R7: A write changes only the addressed word. The other seven keep their values.
- R8: During a read, an address change moves data_io to the newly selected word with no clock involved.
- R9: At most one word latch enable is active at any time, and none is active unless cs_i and wr_i are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 3 | Word address |
| cs_i | input | 1 | Chip select, active high |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| data_io | inout | 8 | Shared data bus: write data in, read data out, otherwise undriven |

## Verification
The bench builds the block with its default values: a 3-bit address and an 8-bit word. At that size every one of the eight locations can be written and read back, and every word can be checked for disturbance after a write to another address. A weak pull-up on the bench side of the bus makes an undriven bus read as all ones. A word holding zero is kept addressed during the float checks, so a driven bus and a floating bus give different values. The bench changes the address several times within one clock period while reading, which shows that the read path needs no clock edge.

// File: rtl/latram_pkg.sv
package latram_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_READ  = 2'd1,
    BUS_WRITE = 2'd2
  } bus_mode_e;
endpackage

// File: rtl/latram_ctrl.sv
module latram_ctrl
  import latram_pkg::*;
(
  input  logic      cs_i,
  input  logic      rd_i,
  input  logic      wr_i,
  output bus_mode_e mode_o
);
  // write wins if both strobes rise, so the bus is never driven into a write
  always_comb begin
    if (!cs_i)     mode_o = BUS_IDLE;
    else if (wr_i) mode_o = BUS_WRITE;
    else if (rd_i) mode_o = BUS_READ;
    else           mode_o = BUS_IDLE;
  end
endmodule

// File: rtl/latram_dec.sv
module latram_dec
  import latram_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  bus_mode_e         mode_i,
  output logic [DEPTH-1:0]  word_we_o
);
  for (genvar w = 0; w < DEPTH; w++) begin : g_dec
    assign word_we_o[w] = (mode_i == BUS_WRITE) && (addr_i == ADDR_W'(w));
  end
endmodule

// File: rtl/latram_word.sv
module latram_word #(
  parameter int DATA_W = 8
) (
  input  logic              we_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_latch begin
      if (we_i) q_o[b] <= d_i[b];
    end
  end
endmodule

// File: rtl/latram_rdmux.sv
module latram_rdmux #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DEPTH-1:0][DATA_W-1:0]  mem_i,
  output logic [DATA_W-1:0]             rd_word_o
);
  assign rd_word_o = mem_i[addr_i];
endmodule

// File: rtl/latram_8x8.sv
module latram_8x8
  import latram_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  inout  wire  [DATA_W-1:0] data_io
);
  bus_mode_e                   mode;
  logic [DEPTH-1:0]            word_we;
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;
  logic [DATA_W-1:0]           rd_word;
  logic                        drive_en;

  latram_ctrl u_ctrl (
    .cs_i   (cs_i),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .mode_o (mode)
  );

  latram_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i    (addr_i),
    .mode_i    (mode),
    .word_we_o (word_we)
  );

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    latram_word #(.DATA_W(DATA_W)) u_word (
      .we_i (word_we[w]),
      .d_i  (data_io),
      .q_o  (mem_q[w])
    );
  end

  latram_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdmux (
    .addr_i    (addr_i),
    .mem_i     (mem_q),
    .rd_word_o (rd_word)
  );

  assign drive_en = (mode == BUS_READ);
  assign data_io  = drive_en ? rd_word : {DATA_W{1'bz}};
endmodule

// File: rtl/latram_chk.sv
module latram_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic [ADDR_W-1:0]             addr_i,
  input logic                          cs_i,
  input logic                          rd_i,
  input logic                          wr_i,
  input logic [DEPTH-1:0]              word_we,
  input logic [DEPTH-1:0][DATA_W-1:0]  mem_q,
  input logic [DATA_W-1:0]             rd_word,
  input logic                          drive_en
);
  always_comb begin
    assert_we_onehot_R9: assert ($onehot0(word_we));
    if (!(cs_i && wr_i)) begin
      assert_no_we_idle_R5: assert (word_we == '0);
    end
    if (cs_i && wr_i) begin
      assert_we_addr_R1: assert (word_we[addr_i]);
    end
    if (!cs_i) begin
      assert_float_desel_R3: assert (!drive_en);
    end
    if (cs_i && !rd_i && !wr_i) begin
      assert_float_idle_R4: assert (!drive_en);
    end
    if (drive_en) begin
      assert_rd_word_R2: assert (rd_word == mem_q[addr_i]);
    end
  end
endmodule

bind latram_8x8 latram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .addr_i   (addr_i),
  .cs_i     (cs_i),
  .rd_i     (rd_i),
  .wr_i     (wr_i),
  .word_we  (word_we),
  .mem_q    (mem_q),
  .rd_word  (rd_word),
  .drive_en (drive_en)
);

// File: tb/sim_latram_8x8.sv
`timescale 1ns/1ps
module sim_latram_8x8;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam logic [DW-1:0] FLOAT = 8'hFF;

  logic          clk = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic          tb_en = 1'b0;
  logic [DW-1:0] tb_val = '0;
  wire  [DW-1:0] bus;

  int checks = 0, fails = 0;
  bit model_on = 1'b0;
  string cur_tag = "R1";
  logic [DW-1:0] model [N];
  bit known [N];

  always #10 clk = ~clk;

  for (genvar i = 0; i < DW; i++) begin : g_pu
    pullup (bus[i]);
  end
  assign bus = tb_en ? tb_val : {DW{1'bz}};

  latram_8x8 u0 (
    .addr_i  (addr),
    .cs_i    (cs),
    .rd_i    (rd),
    .wr_i    (wr),
    .data_io (bus)
  );

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: bus=%h expected=%h addr=%0d", tag, act, exp, addr);
    end
  endtask

  // reference model, compared every clock at the falling edge
  always @(negedge clk) begin
    if (model_on) begin
      if (tb_en) chk(bus, tb_val, cur_tag);
      else if (cs && rd && !wr) begin
        if (known[addr]) chk(bus, model[addr], cur_tag);
      end else chk(bus, FLOAT, cur_tag);
      if (cs && wr) begin
        model[addr] = bus;
        known[addr] = 1'b1;
      end
    end
  end

  task automatic step;
    @(posedge clk);
    #2;
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] v);
    step; addr = AW'(a); tb_val = v; tb_en = 1'b1; cs = 1'b1;
    step; wr = 1'b1;
    step; wr = 1'b0;
    step; tb_en = 1'b0; cs = 1'b0;
  endtask

  task automatic do_read(input int a);
    step; addr = AW'(a); cs = 1'b1; rd = 1'b1;
    step; rd = 1'b0; cs = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return (i == 5) ? 8'h00 : DW'(8'h3C ^ (i * 37));
  endfunction

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) known[i] = 1'b0;
    step;
    // reset state: deselected, bus must float (R3)
    #5 chk(bus, FLOAT, "R3");
    model_on = 1'b1;

    cur_tag = "R1";
    for (int i = 0; i < N; i++) do_write(i, pat(i));
    cur_tag = "R2";
    for (int i = 0; i < N; i++) do_read(i);

    // float cases with a zero word addressed
    cur_tag = "R3";
    step; addr = 3'd5; cs = 1'b0; rd = 1'b1;
    step; rd = 1'b0; wr = 1'b1;
    step; wr = 1'b0;
    cur_tag = "R4";
    step; cs = 1'b1;
    step; #3 chk(bus, FLOAT, "R4"); cs = 1'b0;

    // write strobe while deselected must not store
    cur_tag = "R5";
    step; addr = 3'd2; tb_val = 8'hAA; tb_en = 1'b1;
    step; wr = 1'b1;
    step; wr = 1'b0;
    step; tb_en = 1'b0;
    do_read(2);
    step; addr = 3'd2; cs = 1'b1; rd = 1'b1;
    #3 chk(bus, pat(2), "R5");
    step; rd = 1'b0; cs = 1'b0;

    // transparency while write held, last value kept
    cur_tag = "R6";
    step; addr = 3'd3; tb_val = 8'h11; tb_en = 1'b1; cs = 1'b1;
    step; wr = 1'b1;
    step; tb_val = 8'h77;
    step; tb_val = 8'hC5;
    step; wr = 1'b0;
    step; tb_en = 1'b0; cs = 1'b0;
    step; rd = 1'b1; cs = 1'b1;
    #3 chk(bus, 8'hC5, "R6");
    step; rd = 1'b0; cs = 1'b0;

    // neighbours untouched
    cur_tag = "R7";
    for (int i = 0; i < N; i++) begin
      step; addr = AW'(i); cs = 1'b1; rd = 1'b1;
      #3 chk(bus, (i == 3) ? 8'hC5 : pat(i), "R7");
    end
    step; rd = 1'b0; cs = 1'b0;

    // address change inside one clock period during read
    cur_tag = "R8";
    step; cs = 1'b1; rd = 1'b1; addr = 3'd0;
    for (int i = 1; i < N; i++) begin
      #1 addr = AW'(i);
      #1 chk(bus, (i == 3) ? 8'hC5 : pat(i), "R8");
    end
    step; rd = 1'b0; cs = 1'b0;
    #3 chk(bus, FLOAT, "R3");
    step; step;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule